// File: doc/BRIEF.md
# Round-Robin Pipelined ADC Scan Sequencer

This block sits on the host side of an 8-channel sampling converter that works in pipelined read mode. Each read strobe does two things at once: it returns the byte from the conversion started by the previous strobe, and it starts a new conversion on the channel address presented now. The sequencer drives the chip-select, read strobe and channel address lines. It walks the enabled channels in rotating order and sorts the returned bytes into a bank of per-channel result registers. Each register has a fresh-data flag that the host clears by reading it.

The byte returned by a strobe always belongs to the channel addressed one strobe earlier. A small pending-channel record tracks that channel. After a start, or after the enable mask changes, the first strobe returns a byte that belongs to no channel of the current scan, and the block drops it. The block also enforces the timing windows of the converter: the address settles before the strobe and holds after it, the strobe has a fixed width, and a strobe never starts sooner than a fixed number of clocks after the previous one. All three windows are parameters counted in clock cycles. The default spacing of 250 cycles at 100 MHz gives 2.5 µs per strobe, or 400 kHz shared across the enabled channels.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `adc_cs_n` and `adc_rd_n` are 1 and `result_valid` is all zeros. Every result register reads 0 until it is first written.
- R2: `adc_cs_n` and `adc_rd_n` always carry the same value. Each low pulse lasts exactly `PULSE_CYC` clock cycles.
- R3: Two successive strobe falling edges are at least `SPACING_CYC` clock cycles apart, across stops and restarts as well.
- R4: `adc_addr` is unchanged for at least `SETUP_CYC` cycles before a strobe falls. It stays unchanged while the strobe is low and for the cycle in which it rises.
- R5: Strobes visit only channels whose `chan_mask` bit is 1. After a start or a mask change, the first strobe addresses the lowest enabled channel. Each later strobe addresses the next enabled channel above the previous one, wrapping from channel `N_CH-1` to channel 0.
- R6: The byte on `adc_data` in the last cycle of a strobe is written to the result register of the channel addressed by the strobe before it. That channel's flag in `result_valid` rises in the same cycle in which the strobe rises.
- R7: The first strobe after `run` rises, and the first strobe after any change of `chan_mask`, writes no result register and sets no flag.
- R8: When `host_rd_en` is 1 with `host_rd_sel` = k and no write to channel k lands in that cycle, flag k is 0 from the next cycle on. A write to channel k in the same cycle takes priority.
- R9: While `run` is 0 or `chan_mask` is zero, no new strobe starts. A strobe already low runs to its full width.
- R10: `host_rd_data` shows result register `host_rd_sel` in the same cycle, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1 = keep scanning, 0 = stop after the current strobe |
| chan_mask | input | N_CH | Per-channel scan enable |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_addr | output | $clog2(N_CH) | Converter channel address |
| adc_data | input | DW | Byte returned by the converter during a strobe |
| host_rd_en | input | 1 | Host read of one result register; clears its flag |
| host_rd_sel | input | $clog2(N_CH) | Result register chosen by the host |
| host_rd_data | output | DW | Content of the chosen result register |
| result_valid | output | N_CH | Per-channel fresh-result flags |

## Verification
A bad pending-channel record shows up on the first write after the fault. The result lands in the slot of the channel addressed by the same strobe instead of the previous one, so every slot compared after the run holds a neighbour's sample. A missed restart clears nothing, so a stale byte appears as a valid result within the first strobe of a scan. A wrong rotation or timing count is visible on the converter pins at the very next strobe, through the address sequence, the strobe width or the spacing between strobes.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    typedef enum logic [1:0] {
        SCN_IDLE  = 2'd0,
        SCN_SETUP = 2'd1,
        SCN_PULSE = 2'd2,
        SCN_HOLD  = 2'd3
    } scan_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/scan_rr_pick.sv
`timescale 1ns/1ps
module scan_rr_pick #(
    parameter int unsigned N_CH = 8,
    localparam int unsigned CHW = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] mask,
    input  logic [CHW-1:0]  cur,
    output logic [CHW-1:0]  nxt
);
    // Search upward from cur+1, wrapping; cur itself is the last candidate.
    always_comb begin
        logic found;
        found = 1'b0;
        nxt   = cur;
        for (int k = 1; k <= int'(N_CH); k++) begin
            int idx;
            idx = (int'(cur) + k) % int'(N_CH);
            if (!found && mask[idx]) begin
                nxt   = CHW'(idx);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_gap_timer.sv
`timescale 1ns/1ps
module scan_gap_timer #(
    parameter int unsigned LIMIT = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic done
);
    localparam int unsigned CW = scan_pkg::cnt_width(LIMIT);

    logic [CW-1:0] cnt;

    // Saturating count of cycles since the last strobe start; out of reset it
    // starts saturated so the first strobe is not delayed.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CW'(LIMIT);
        else if (clear)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= CW'(LIMIT - 1));
endmodule

// File: rtl/scan_result_bank.sv
`timescale 1ns/1ps
module scan_result_bank #(
    parameter int unsigned N_CH = 8,
    parameter int unsigned DW   = 8,
    localparam int unsigned CHW = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CHW-1:0]  wr_ch,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    input  logic [CHW-1:0]  rd_ch,
    output logic [DW-1:0]   rd_data,
    output logic [N_CH-1:0] valid
);
    logic [DW-1:0] slot [N_CH];

    for (genvar g = 0; g < int'(N_CH); g++) begin : g_slot
        logic hit_wr;
        logic hit_rd;
        assign hit_wr = wr_en && (wr_ch == CHW'(g));
        assign hit_rd = rd_en && (rd_ch == CHW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g]  <= '0;
                valid[g] <= 1'b0;
            end else if (hit_wr) begin
                slot[g]  <= wr_data;
                valid[g] <= 1'b1;
            end else if (hit_rd) begin
                valid[g] <= 1'b0;
            end
        end
    end

    assign rd_data = slot[rd_ch];
endmodule

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl #(
    parameter int unsigned N_CH        = 8,
    parameter int unsigned DW          = 8,
    parameter int unsigned PULSE_CYC   = 4,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned SPACING_CYC = 250,
    localparam int unsigned CHW = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [N_CH-1:0] chan_mask,
    output logic            adc_cs_n,
    output logic            adc_rd_n,
    output logic [CHW-1:0]  adc_addr,
    input  logic [DW-1:0]   adc_data,
    input  logic            host_rd_en,
    input  logic [CHW-1:0]  host_rd_sel,
    output logic [DW-1:0]   host_rd_data,
    output logic [N_CH-1:0] result_valid
);
    import scan_pkg::*;

    localparam int unsigned PHW = cnt_width(max_u(PULSE_CYC, SETUP_CYC));
    localparam logic [PHW-1:0] SETUP_LAST = PHW'(SETUP_CYC - 1);
    localparam logic [PHW-1:0] PULSE_LAST = PHW'(PULSE_CYC - 1);

    scan_state_e      state;
    logic             strobe_n;
    logic [CHW-1:0]   addr_q;
    logic [PHW-1:0]   ph_cnt;
    logic [N_CH-1:0]  act_mask;
    logic             pend_vld;
    logic [CHW-1:0]   pend_ch;

    logic             go;
    logic             mask_moved;
    logic             gap_done;
    logic             start_pulse;
    logic             end_pulse;
    logic [CHW-1:0]   pick_from;
    logic [CHW-1:0]   pick_ch;

    assign go          = run && (chan_mask != '0);
    assign mask_moved  = (chan_mask != act_mask);
    assign start_pulse = (state == SCN_SETUP) && go && !mask_moved
                         && (ph_cnt == SETUP_LAST) && gap_done;
    assign end_pulse   = (state == SCN_PULSE) && (ph_cnt == PULSE_LAST);

    // From idle the search starts just above the top channel, i.e. at channel 0.
    assign pick_from = (state == SCN_IDLE) ? CHW'(N_CH - 1) : addr_q;

    scan_rr_pick #(.N_CH(N_CH)) u_pick (
        .mask (chan_mask),
        .cur  (pick_from),
        .nxt  (pick_ch)
    );

    scan_gap_timer #(.LIMIT(SPACING_CYC)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .clear (start_pulse),
        .done  (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SCN_IDLE;
            strobe_n <= 1'b1;
            addr_q   <= '0;
            ph_cnt   <= '0;
            act_mask <= '0;
            pend_vld <= 1'b0;
            pend_ch  <= '0;
        end else begin
            unique case (state)
                SCN_IDLE: begin
                    strobe_n <= 1'b1;
                    pend_vld <= 1'b0;
                    if (go) begin
                        addr_q   <= pick_ch;
                        act_mask <= chan_mask;
                        ph_cnt   <= '0;
                        state    <= SCN_SETUP;
                    end
                end
                SCN_SETUP: begin
                    if (!go || mask_moved) begin
                        state <= SCN_IDLE;
                    end else if (start_pulse) begin
                        strobe_n <= 1'b0;
                        ph_cnt   <= '0;
                        state    <= SCN_PULSE;
                    end else if (ph_cnt != SETUP_LAST) begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SCN_PULSE: begin
                    if (end_pulse) begin
                        strobe_n <= 1'b1;
                        pend_vld <= 1'b1;
                        pend_ch  <= addr_q;
                        state    <= SCN_HOLD;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SCN_HOLD: begin
                    if (!go || mask_moved) begin
                        state <= SCN_IDLE;
                    end else begin
                        addr_q <= pick_ch;
                        ph_cnt <= '0;
                        state  <= SCN_SETUP;
                    end
                end
                default: state <= SCN_IDLE;
            endcase
        end
    end

    scan_result_bank #(.N_CH(N_CH), .DW(DW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (end_pulse && pend_vld),
        .wr_ch   (pend_ch),
        .wr_data (adc_data),
        .rd_en   (host_rd_en),
        .rd_ch   (host_rd_sel),
        .rd_data (host_rd_data),
        .valid   (result_valid)
    );

    assign adc_cs_n = strobe_n;
    assign adc_rd_n = strobe_n;
    assign adc_addr = addr_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
`timescale 1ns/1ps
module adc_scan_ctrl_chk #(
    parameter int unsigned N_CH        = 8,
    parameter int unsigned PULSE_CYC   = 4,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned SPACING_CYC = 250,
    localparam int unsigned CHW = $clog2(N_CH)
) (
    input logic            clk,
    input logic            rst,
    input logic            run,
    input logic [N_CH-1:0] chan_mask,
    input logic            adc_cs_n,
    input logic            adc_rd_n,
    input logic [CHW-1:0]  adc_addr,
    input logic            host_rd_en,
    input logic [CHW-1:0]  host_rd_sel,
    input logic [N_CH-1:0] result_valid
);
    localparam int unsigned LW = scan_pkg::cnt_width(PULSE_CYC + 1);
    localparam int unsigned GW = scan_pkg::cnt_width(SPACING_CYC);
    localparam int unsigned SW = scan_pkg::cnt_width(SETUP_CYC);

    logic            cs_d;
    logic [N_CH-1:0] mask_d;
    logic [N_CH-1:0] valid_d;
    logic [CHW-1:0]  addr_d;
    logic [CHW-1:0]  sel_d;
    logic [LW-1:0]   low_cnt;
    logic [GW-1:0]   since_fall;
    logic [SW-1:0]   stab_cnt;
    logic            seen_fall;
    logic            fall_now;

    assign fall_now = cs_d && !adc_cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d       <= 1'b1;
            mask_d     <= '0;
            valid_d    <= '0;
            addr_d     <= '0;
            sel_d      <= '0;
            low_cnt    <= '0;
            since_fall <= '0;
            stab_cnt   <= '0;
            seen_fall  <= 1'b0;
        end else begin
            cs_d    <= adc_cs_n;
            mask_d  <= chan_mask;
            valid_d <= result_valid;
            addr_d  <= adc_addr;
            sel_d   <= host_rd_sel;
            if (!adc_cs_n) begin
                if (low_cnt != LW'(PULSE_CYC + 1)) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            if (fall_now) begin
                since_fall <= GW'(1);
                seen_fall  <= 1'b1;
            end else if (since_fall != GW'(SPACING_CYC)) begin
                since_fall <= since_fall + 1'b1;
            end
            if (adc_addr != addr_d)
                stab_cnt <= SW'(1);
            else if (stab_cnt != SW'(SETUP_CYC))
                stab_cnt <= stab_cnt + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (adc_cs_n && adc_rd_n && (result_valid == '0)));

    assert_strobes_paired_R2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n == adc_rd_n);

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
        (adc_cs_n && !cs_d) |-> (low_cnt == LW'(PULSE_CYC)));

    assert_read_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (fall_now && seen_fall) |-> (since_fall >= GW'(SPACING_CYC)));

    assert_addr_setup_R4: assert property (@(posedge clk) disable iff (rst)
        fall_now |-> (stab_cnt >= SW'(SETUP_CYC)));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n || !cs_d) |-> (adc_addr == addr_d));

    assert_enabled_channel_R5: assert property (@(posedge clk) disable iff (rst)
        fall_now |-> mask_d[adc_addr]);

    assert_valid_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        ((result_valid & ~valid_d) != '0) |-> (adc_cs_n && !cs_d));

    assert_host_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && adc_cs_n) |=> !result_valid[sel_d]);

    assert_no_start_when_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        (adc_cs_n && (!run || (chan_mask == '0))) |=> adc_cs_n);
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
    .N_CH        (N_CH),
    .PULSE_CYC   (PULSE_CYC),
    .SETUP_CYC   (SETUP_CYC),
    .SPACING_CYC (SPACING_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .chan_mask    (chan_mask),
    .adc_cs_n     (adc_cs_n),
    .adc_rd_n     (adc_rd_n),
    .adc_addr     (adc_addr),
    .host_rd_en   (host_rd_en),
    .host_rd_sel  (host_rd_sel),
    .result_valid (result_valid)
);

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb;
    localparam int N_CH    = 8;
    localparam int DW      = 8;
    localparam int PULSE   = 3;
    localparam int SETUP   = 2;
    localparam int SPACING = 24;
    localparam int CHW     = $clog2(N_CH);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            run = 1'b0;
    logic [N_CH-1:0] chan_mask = '0;
    logic            adc_cs_n, adc_rd_n;
    logic [CHW-1:0]  adc_addr;
    logic [DW-1:0]   adc_data = 8'hEE;
    logic            host_rd_en = 1'b0;
    logic [CHW-1:0]  host_rd_sel = '0;
    logic [DW-1:0]   host_rd_data;
    logic [N_CH-1:0] result_valid;

    always #5 clk = ~clk;

    adc_scan_ctrl #(
        .N_CH(N_CH), .DW(DW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP), .SPACING_CYC(SPACING)
    ) u_dut (
        .clk(clk), .rst(rst), .run(run), .chan_mask(chan_mask),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_addr(adc_addr), .adc_data(adc_data),
        .host_rd_en(host_rd_en), .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .result_valid(result_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] smp(input int ch, input int seq);
        return DW'(ch * 37 + seq * 13 + 7);
    endfunction

    function automatic int next_en(input logic [N_CH-1:0] m, input int cur);
        for (int k = 1; k <= N_CH; k++) begin
            if (m[(cur + k) % N_CH]) return (cur + k) % N_CH;
        end
        return cur;
    endfunction

    // Converter model and bus monitor, sampled on the falling clock edge.
    logic [DW-1:0]   out_next = 8'hEE;
    logic [DW-1:0]   exp_bank [N_CH];
    logic [N_CH-1:0] exp_valid = '0;
    bit   fresh = 1'b1;
    bit   pv = 1'b0;
    bit   have_prev = 1'b0;
    bit   prev_cs = 1'b1;
    int   pch = 0, last_ch = 0, seq = 0;
    int   since = 0, stab = 0, low_cnt = 0, starts = 0, ends = 0;
    logic [CHW-1:0] prev_addr = '0;

    initial for (int i = 0; i < N_CH; i++) exp_bank[i] = '0;

    always @(negedge clk) begin
        if (!rst) begin
            since++;
            if (adc_addr != prev_addr) stab = 0; else stab++;
            if (!adc_cs_n) low_cnt++;
            check(adc_cs_n == adc_rd_n, "R2 strobes paired", adc_rd_n, adc_cs_n);
            if (!adc_cs_n && prev_cs) begin
                int e;
                e = fresh ? next_en(chan_mask, N_CH - 1) : next_en(chan_mask, last_ch);
                check(int'(adc_addr) == e, "R5 channel order", int'(adc_addr), e);
                if (have_prev) check(since >= SPACING, "R3 spacing", since, SPACING);
                check(stab >= SETUP, "R4 address setup", stab, SETUP);
                if (fresh) pv = 1'b0;
                if (pv) begin
                    exp_bank[pch] = out_next;
                    exp_valid[pch] = 1'b1;
                end
                adc_data <= out_next;
                out_next = smp(int'(adc_addr), seq);
                seq++;
                pch = int'(adc_addr);
                last_ch = pch;
                pv = 1'b1;
                fresh = 1'b0;
                have_prev = 1'b1;
                since = 0;
                starts++;
            end
            if (adc_cs_n && !prev_cs) begin
                check(low_cnt == PULSE, "R2 pulse width", low_cnt, PULSE);
                check(adc_addr == prev_addr, "R4 address hold", int'(adc_addr), int'(prev_addr));
                ends++;
            end
            if (adc_cs_n) low_cnt = 0;
            prev_cs = adc_cs_n;
            prev_addr = adc_addr;
        end
    end

    task automatic host_read(input int k);
        @(negedge clk);
        host_rd_en = 1'b1;
        host_rd_sel = CHW'(k);
        #1;
        check(host_rd_data == exp_bank[k], "R6/R10 result data", int'(host_rd_data), int'(exp_bank[k]));
        check(result_valid[k] == exp_valid[k], "R6 valid flag", int'(result_valid[k]), int'(exp_valid[k]));
        @(negedge clk);
        host_rd_en = 1'b0;
        #1;
        check(result_valid[k] == 1'b0, "R8 flag cleared by host read", int'(result_valid[k]), 0);
        exp_valid[k] = 1'b0;
    endtask

    task automatic stop_and_drain();
        @(negedge clk);
        run = 1'b0;
        repeat (PULSE + SPACING + 4) @(negedge clk);
    endtask

    task automatic scan_with(input logic [N_CH-1:0] m, input int cycles);
        @(negedge clk);
        chan_mask = m;
        fresh = 1'b1;
        run = 1'b1;
        repeat (cycles) @(negedge clk);
        stop_and_drain();
        for (int k = 0; k < N_CH; k++) host_read(k);
    endtask

    initial begin
        logic [N_CH-1:0] masks [6];
        int s0;
        masks[0] = 8'hFF; masks[1] = 8'h01; masks[2] = 8'hA5;
        masks[3] = 8'h80; masks[4] = 8'h5A; masks[5] = 8'h81;

        repeat (4) @(negedge clk);
        check(adc_cs_n && adc_rd_n, "R1 strobes idle in reset", int'(adc_cs_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check(adc_cs_n && adc_rd_n, "R1 strobes idle after reset", int'(adc_cs_n), 1);
        check(result_valid == '0, "R1 flags clear after reset", int'(result_valid), 0);
        for (int k = 0; k < N_CH; k++) host_read(k);

        for (int i = 0; i < 6; i++) scan_with(masks[i], 20 * SPACING);

        // R7: the first strobe of a scan writes nothing.
        @(negedge clk);
        chan_mask = 8'h04;
        fresh = 1'b1;
        run = 1'b1;
        s0 = ends;
        while (ends == s0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(result_valid == '0, "R7 first strobe discarded", int'(result_valid), 0);
        while (ends == s0 + 1) @(negedge clk);
        repeat (2) @(negedge clk);
        check(result_valid == 8'h04, "R7 second strobe writes", int'(result_valid), 4);
        stop_and_drain();
        for (int k = 0; k < N_CH; k++) host_read(k);

        // R7: mask change during a scan restarts the rotation and drops one byte.
        @(negedge clk);
        chan_mask = 8'hFF;
        fresh = 1'b1;
        run = 1'b1;
        repeat (5 * SPACING + 7) @(negedge clk);
        while (!adc_cs_n) @(negedge clk);
        chan_mask = 8'h0C;
        fresh = 1'b1;
        repeat (10 * SPACING) @(negedge clk);
        stop_and_drain();
        for (int k = 0; k < N_CH; k++) host_read(k);

        // R9: no strobe with a zero mask, nor with run low.
        s0 = starts;
        @(negedge clk);
        chan_mask = '0;
        run = 1'b1;
        repeat (4 * SPACING) @(negedge clk);
        check(starts == s0, "R9 zero mask idles", starts - s0, 0);
        run = 1'b0;
        chan_mask = 8'hFF;
        repeat (4 * SPACING) @(negedge clk);
        check(starts == s0, "R9 run low idles", starts - s0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule